// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns one internal read or write request at a time into a complete cycle on an external 16-bit bus that carries address and data over the same lines. Each cycle begins with an address phase flagged by an address-enable strobe. An optional extra address hold cycle may follow. A single-cycle read or write strobe then moves the data. The cycle closes with an optional write hold cycle or an optional bus-turnaround cycle after a read.

Four memory-select outputs address four external devices. Each select has its own 16-bit timing word, so slow and fast devices can share the bus. The word sets the number of address wait states and turns the hold and turnaround cycles on or off. The block also drives separate high-byte and low-byte enables. All outputs come straight from flops clocked by the bus clock. The internal side is a valid/ready pair: ready stays low from acceptance until the last cycle of the external transfer has completed, and the read result is then available on the read-data output.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, `req_ready` is low, `ext_ae` and `ext_ad_oe` are low, and every select, strobe and byte enable (all active low) is high. Once `port_en` is high and the block is idle, `req_ready` rises on the next cycle.
- R2: While `port_en` is low, `req_valid` is ignored: `req_ready` stays low and no address phase starts.
- R3: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Let W be bits [14:12] of the chosen select's timing word. `ext_ae` is then high for exactly W+1 cycles while `req_addr` is driven with `ext_ad_oe` high. During these cycles only `ext_sel_n[req_sel]` is low.
- R4: When bit 10 of the chosen timing word is set, one extra cycle follows the fall of `ext_ae` and comes before the strobe. In that cycle the address is still driven. When the bit is clear, the strobe comes directly after the address phase.
- R5: A read asserts `ext_rd_n` low for one cycle with `ext_ad_oe` low. `ext_ad_i` is captured at the clock edge that ends that cycle and appears on `req_rdata`.
- R6: A write asserts `ext_wr_n` low for one cycle while `req_wdata` is driven with `ext_ad_oe` high.
- R7: When bit 8 of the chosen timing word is set, a write gets one hold cycle after `ext_wr_n` rises. In that cycle the data stays driven and the select stays low. Without the bit, the select is released right after the strobe.
- R8: When bit 9 is set, a read gets one turnaround cycle after `ext_rd_n` rises, with the bus released, before ready returns. Bit 9 has no effect on writes and bit 8 has no effect on reads.
- R9: While a select is low, `ext_bhe_n` equals the inverse of `req_be[1]` and `ext_ble_n` equals the inverse of `req_be[0]`, as captured with the request.
- R10: `req_ready` is low for exactly (W+1) + A + 1 + E cycles after acceptance. A is bit 10. E is bit 8 for writes and bit 9 for reads. Each select's own timing word applies, and all other bits of the word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Global enable of the external port |
| cfg_all | input | 64 | Four 16-bit timing words, select i at bits [16i+15:16i] |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Memory select index |
| req_addr | input | 16 | Address placed on the bus |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lanes: bit 1 high byte, bit 0 low byte |
| req_ready | output | 1 | High when a request can be taken |
| req_rdata | output | 16 | Data captured by the last read |
| ext_ad_o | output | 16 | Shared address/data lines, outgoing value |
| ext_ad_oe | output | 1 | Drive enable for the shared lines |
| ext_ad_i | input | 16 | Shared address/data lines, incoming value |
| ext_ae | output | 1 | Address enable strobe, active high |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_sel_n | output | 4 | Memory selects, active low |
| ext_bhe_n | output | 1 | High-byte enable, active low |
| ext_ble_n | output | 1 | Low-byte enable, active low |

## Verification
The hardest case to reach from the ports is a cycle that uses every optional phase at once: the longest wait count, address hold, and write hold or turnaround. Another hard case is a timing word whose unused bits are all set. In both cases one select's settings could leak into a neighbour's cycle. The stimulus gives the four selects very different timing words, one of them full of junk bits, and alternates reads and writes across all four. A bus model answers reads with a value derived from the latched address. A scoreboard compares each bus phase length and each driven value against the queued request.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int CFG_W     = 16;
    localparam int WAIT_W    = 3;
    localparam int WAIT_LSB  = 12;
    localparam int AHOLD_BIT = 10;
    localparam int TURN_BIT  = 9;
    localparam int WHOLD_BIT = 8;

    typedef struct packed {
        logic [WAIT_W-1:0] wait_n;
        logic              ahold;
        logic              turn;
        logic              whold;
    } tcfg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_AHLD,
        S_RD,
        S_WR,
        S_WHLD,
        S_TURN
    } xstate_e;

endpackage

// File: rtl/xbus_cfg_pick.sv
module xbus_cfg_pick
    import xbus_pkg::*;
#(
    parameter int NSEL = 4,
    localparam int SW  = $clog2(NSEL)
) (
    input  logic [NSEL*CFG_W-1:0] cfg_all,
    input  logic [SW-1:0]         sel,
    output tcfg_t                 cfg
);

    tcfg_t fields [NSEL];

    for (genvar i = 0; i < NSEL; i++) begin : g_unpack
        assign fields[i].wait_n = cfg_all[i*CFG_W + WAIT_LSB +: WAIT_W];
        assign fields[i].ahold  = cfg_all[i*CFG_W + AHOLD_BIT];
        assign fields[i].turn   = cfg_all[i*CFG_W + TURN_BIT];
        assign fields[i].whold  = cfg_all[i*CFG_W + WHOLD_BIT];
    end

    logic cfg_unused;
    assign cfg_unused = ^cfg_all;

    assign cfg = fields[sel];

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NSEL = 4,
    localparam int SW  = $clog2(NSEL),
    localparam int BEW = DW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            port_en,
    input  tcfg_t           cfg_in,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [SW-1:0]   req_sel,
    input  logic [DW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [BEW-1:0]  req_be,
    output logic            req_ready,
    output logic [DW-1:0]   req_rdata,
    output logic [DW-1:0]   ad_o,
    output logic            ad_oe,
    input  logic [DW-1:0]   ad_i,
    output logic            ae,
    output logic            rd_n,
    output logic            wr_n,
    output logic [NSEL-1:0] sel_oh,
    output logic [BEW-1:0]  be_n
);

    typedef struct packed {
        xstate_e           state;
        logic [WAIT_W-1:0] cnt;
        tcfg_t             cfg;
        logic              wr;
        logic [DW-1:0]     addr;
        logic [DW-1:0]     wdata;
        logic [BEW-1:0]    be;
        logic [SW-1:0]     sel;
        logic [DW-1:0]     rdata;
        logic              ae;
        logic              rd_n;
        logic              wr_n;
        logic              oe;
        logic [DW-1:0]     ad;
        logic [NSEL-1:0]   sel_oh;
        logic [BEW-1:0]    be_n;
        logic              ready;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        logic active;
        r_d = r_q;

        // next state
        case (r_q.state)
            S_IDLE: begin
                if (port_en && req_valid && r_q.ready) begin
                    r_d.state = S_ADDR;
                    r_d.cnt   = cfg_in.wait_n;
                    r_d.cfg   = cfg_in;
                    r_d.wr    = req_write;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.be    = req_be;
                    r_d.sel   = req_sel;
                end
            end
            S_ADDR: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.cfg.ahold) begin
                    r_d.state = S_AHLD;
                end else begin
                    r_d.state = r_q.wr ? S_WR : S_RD;
                end
            end
            S_AHLD: r_d.state = r_q.wr ? S_WR : S_RD;
            S_RD: begin
                r_d.rdata = ad_i;
                r_d.state = r_q.cfg.turn ? S_TURN : S_IDLE;
            end
            S_WR:   r_d.state = r_q.cfg.whold ? S_WHLD : S_IDLE;
            S_WHLD: r_d.state = S_IDLE;
            S_TURN: r_d.state = S_IDLE;
            default: r_d.state = S_IDLE;
        endcase

        // registered pin values follow the next state
        active = (r_d.state == S_ADDR) || (r_d.state == S_AHLD) ||
                 (r_d.state == S_RD)   || (r_d.state == S_WR)   ||
                 (r_d.state == S_WHLD);
        r_d.ae   = (r_d.state == S_ADDR);
        r_d.rd_n = (r_d.state != S_RD);
        r_d.wr_n = (r_d.state != S_WR);
        r_d.oe   = (r_d.state == S_ADDR) || (r_d.state == S_AHLD) ||
                   (r_d.state == S_WR)   || (r_d.state == S_WHLD);
        if ((r_d.state == S_ADDR) || (r_d.state == S_AHLD)) begin
            r_d.ad = r_d.addr;
        end else if ((r_d.state == S_WR) || (r_d.state == S_WHLD)) begin
            r_d.ad = r_d.wdata;
        end else begin
            r_d.ad = '0;
        end
        for (int i = 0; i < NSEL; i++) begin
            r_d.sel_oh[i] = active && (r_d.sel == SW'(i));
        end
        r_d.be_n  = active ? ~r_d.be : '1;
        r_d.ready = (r_d.state == S_IDLE) && port_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= S_IDLE;
            r_q.rd_n   <= 1'b1;
            r_q.wr_n   <= 1'b1;
            r_q.be_n   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = r_q.ready;
    assign req_rdata = r_q.rdata;
    assign ad_o      = r_q.ad;
    assign ad_oe     = r_q.oe;
    assign ae        = r_q.ae;
    assign rd_n      = r_q.rd_n;
    assign wr_n      = r_q.wr_n;
    assign sel_oh    = r_q.sel_oh;
    assign be_n      = r_q.be_n;

    // R2: a disabled port never leaves idle
    a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_IDLE && !port_en) |=> (r_q.state == S_IDLE));

    // R3: never more than one select low
    a_r3_one_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh));

    // R3: the address phase always has a select
    a_r3_ae_sel: assert property (@(posedge clk) disable iff (!rst_n)
        ae |-> (sel_oh != '0));

    // R5: the bus is released while the read strobe is low
    a_r5_rd_float: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!ad_oe && wr_n));

    // R6: data is driven while the write strobe is low
    a_r6_wr_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe && rd_n));

    // R10: ready only while the bus is quiet
    a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rd_n && wr_n && !ae && sel_oh == '0));

    // R5: a strobe lasts a single cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |=> (rd_n && wr_n));

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NSEL = 4,
    localparam int SW  = $clog2(NSEL),
    localparam int BEW = DW / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  port_en,
    input  logic [NSEL*CFG_W-1:0] cfg_all,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [SW-1:0]         req_sel,
    input  logic [DW-1:0]         req_addr,
    input  logic [DW-1:0]         req_wdata,
    input  logic [BEW-1:0]        req_be,
    output logic                  req_ready,
    output logic [DW-1:0]         req_rdata,
    output logic [DW-1:0]         ext_ad_o,
    output logic                  ext_ad_oe,
    input  logic [DW-1:0]         ext_ad_i,
    output logic                  ext_ae,
    output logic                  ext_rd_n,
    output logic                  ext_wr_n,
    output logic [NSEL-1:0]       ext_sel_n,
    output logic                  ext_bhe_n,
    output logic                  ext_ble_n
);

    tcfg_t           cfg_sel;
    logic [NSEL-1:0] sel_oh;
    logic [BEW-1:0]  be_n;

    xbus_cfg_pick #(.NSEL(NSEL)) u_pick (
        .cfg_all (cfg_all),
        .sel     (req_sel),
        .cfg     (cfg_sel)
    );

    xbus_seq #(.DW(DW), .NSEL(NSEL)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .cfg_in    (cfg_sel),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_sel   (req_sel),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .req_ready (req_ready),
        .req_rdata (req_rdata),
        .ad_o      (ext_ad_o),
        .ad_oe     (ext_ad_oe),
        .ad_i      (ext_ad_i),
        .ae        (ext_ae),
        .rd_n      (ext_rd_n),
        .wr_n      (ext_wr_n),
        .sel_oh    (sel_oh),
        .be_n      (be_n)
    );

    assign ext_sel_n = ~sel_oh;
    assign ext_bhe_n = be_n[BEW-1];
    assign ext_ble_n = be_n[0];

endmodule

// File: tb/sim_xbus_ctrl.sv
module sim_xbus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic [63:0] cfg_all;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_sel = '0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready;
    logic [15:0] req_rdata;
    logic [15:0] ext_ad_o;
    logic        ext_ad_oe;
    logic [15:0] ext_ad_i = 16'hDEAD;
    logic        ext_ae;
    logic        ext_rd_n;
    logic        ext_wr_n;
    logic [3:0]  ext_sel_n;
    logic        ext_bhe_n;
    logic        ext_ble_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    typedef struct {
        int          sel;
        bit          wr;
        logic [15:0] addr;
        logic [15:0] data;
        logic [1:0]  be;
        int          w;
        bit          h;
        bit          t;
        bit          x;
    } item_t;

    item_t exp_q[$];

    logic [15:0] cfg_word [4];

    always #5 clk = ~clk;

    xbus_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .cfg_all   (cfg_all),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_sel   (req_sel),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .req_ready (req_ready),
        .req_rdata (req_rdata),
        .ext_ad_o  (ext_ad_o),
        .ext_ad_oe (ext_ad_oe),
        .ext_ad_i  (ext_ad_i),
        .ext_ae    (ext_ae),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n),
        .ext_sel_n (ext_sel_n),
        .ext_bhe_n (ext_bhe_n),
        .ext_ble_n (ext_ble_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver: queue the expectation, issue the request, time the busy window
    task automatic xfer(input int s, input bit w, input logic [15:0] a,
                        input logic [15:0] d, input logic [1:0] be);
        item_t it;
        int n;
        int exp_n;
        while (!req_ready) @(negedge clk);
        it.sel = s; it.wr = w; it.addr = a; it.data = d; it.be = be;
        it.w = int'(cfg_word[s][14:12]);
        it.h = cfg_word[s][10];
        it.t = cfg_word[s][9];
        it.x = cfg_word[s][8];
        exp_q.push_back(it);
        req_sel = 2'(s); req_write = w; req_addr = a; req_wdata = d; req_be = be;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!req_ready && n < 100) begin
            n++;
            @(negedge clk);
        end
        exp_n = it.w + 1 + int'(it.h) + 1 + (w ? int'(it.x) : int'(it.t));
        if (!w && it.t) chk(n == exp_n, "R8 read turnaround busy cycles", n, exp_n);
        else if (w && it.x) chk(n == exp_n, "R7 write hold busy cycles", n, exp_n);
        else chk(n == exp_n, "R10 busy cycles", n, exp_n);
        if (!w) chk(req_rdata == (a ^ 16'h5A3C), "R5 read data", req_rdata, a ^ 16'h5A3C);
    endtask

    // monitor: bus model plus phase-by-phase comparison
    int          ae_cnt = 0;
    int          gap = 0;
    bit          post = 0;
    bit          post_x = 0;
    item_t       cur;
    logic [15:0] seen_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ext_rd_n) ext_ad_i = seen_addr ^ 16'h5A3C;
            else ext_ad_i = 16'hDEAD;

            if (ext_ae) begin
                if (ae_cnt == 0) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected address phase", 1, 0);
                    end else begin
                        cur = exp_q.pop_front();
                    end
                    seen_addr = ext_ad_o;
                    gap = 0;
                end
                ae_cnt++;
            end else if (ae_cnt > 0) begin
                if (!ext_rd_n || !ext_wr_n) begin
                    chk(ae_cnt == cur.w + 1, "R3 address phase length", ae_cnt, cur.w + 1);
                    chk(seen_addr == cur.addr, "R3 address value", seen_addr, cur.addr);
                    chk(ext_sel_n == ~(4'b0001 << cur.sel), "R3 select", ext_sel_n,
                        ~(4'b0001 << cur.sel));
                    chk(gap == int'(cur.h), "R4 address hold length", gap, cur.h);
                    chk({ext_bhe_n, ext_ble_n} == ~cur.be, "R9 byte enables",
                        {ext_bhe_n, ext_ble_n}, ~cur.be);
                    if (cur.wr) begin
                        chk(!ext_wr_n && ext_ad_oe && ext_ad_o == cur.data,
                            "R6 write strobe data", ext_ad_o, cur.data);
                    end else begin
                        chk(!ext_rd_n && !ext_ad_oe, "R5 read strobe float",
                            {ext_rd_n, ext_ad_oe}, 0);
                    end
                    ae_cnt = 0;
                    post = cur.wr;
                    post_x = cur.x;
                end else begin
                    gap++;
                    chk(ext_ad_oe && ext_ad_o == cur.addr, "R4 address held", ext_ad_o,
                        cur.addr);
                end
            end else if (post) begin
                post = 0;
                if (post_x) begin
                    chk(ext_wr_n && ext_ad_oe && ext_ad_o == cur.data &&
                        ext_sel_n == ~(4'b0001 << cur.sel), "R7 write hold cycle",
                        ext_ad_o, cur.data);
                end else begin
                    chk(ext_sel_n == 4'hF, "R7 select released", ext_sel_n, 4'hF);
                end
            end
        end
    end

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        cfg_word[0] = 16'h0000;   // W=0, nothing extra
        cfg_word[1] = 16'h3400;   // W=3, address hold
        cfg_word[2] = 16'h7700;   // W=7, hold, turnaround, write hold
        cfg_word[3] = 16'h99FF;   // W=1, write hold, unused bits set
        cfg_all = {cfg_word[3], cfg_word[2], cfg_word[1], cfg_word[0]};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b0, "R1 ready after reset", req_ready, 0);
        chk(ext_sel_n == 4'hF && ext_rd_n && ext_wr_n && ext_bhe_n && ext_ble_n,
            "R1 inactive strobes", {ext_sel_n, ext_rd_n, ext_wr_n, ext_bhe_n, ext_ble_n},
            8'hFF);
        chk(!ext_ae && !ext_ad_oe, "R1 ae and drive low", {ext_ae, ext_ad_oe}, 0);

        // R2 requests ignored while disabled
        req_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!req_ready && !ext_ae, "R2 disabled port idle", {req_ready, ext_ae}, 0);
        end
        req_valid = 1'b0;
        @(negedge clk);
        port_en = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after enable", req_ready, 1);

        xfer(0, 1, 16'h1234, 16'hBEEF, 2'b11);
        xfer(0, 0, 16'h1234, 16'h0000, 2'b11);
        xfer(1, 1, 16'h0F0F, 16'hA5A5, 2'b01);
        xfer(1, 0, 16'h8001, 16'h0000, 2'b10);
        xfer(2, 1, 16'hFFFE, 16'h00FF, 2'b10);
        xfer(2, 0, 16'h4242, 16'h0000, 2'b01);
        xfer(3, 1, 16'h0002, 16'h7E57, 2'b11);
        xfer(3, 0, 16'h0003, 16'h0000, 2'b11);
        xfer(2, 0, 16'h0000, 16'h0000, 2'b00);
        xfer(0, 1, 16'hFFFF, 16'h0001, 2'b01);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all requests seen on bus", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end

endmodule